// File: doc/BRIEF.md
# Two-Page Window Address Mapper

This block widens a 16-bit processor address into a 20-bit physical address. Two adjacent 256-byte pages of the processor space, CPU pages $20 and $21 (addresses $2000 to $21FF), form a window. The window can be placed on any pair of consecutive physical pages in a 1 MB space. An absolute-indexed access that carries out of the first window page into the second therefore reaches the next physical page, as a flat address space would. Every address outside the window reaches physical memory with its upper four bits set to zero.

The physical page numbers are 12 bits wide and are loaded through a small byte-wide write port. Each value is written in two parts. A low-byte write is held in a staging register. A later high-nibble write joins the nibble to the staged byte and commits the whole number at once, so the mapping never shows a half-written page number. The `USE_ADDER` build parameter chooses how the second window page gets its number. With the adder, it is the first page number plus one, wrapping from $FFF to $000. Without it, a second register holds the number, and software loads that register one higher than the first.

Top module: `pagewin_mapper`

## Requirements
- R1: Only CPU addresses $2000 through $21FF are translated through the window; every other address is outside it.
- R2: An access to CPU page $20 produces physical address {base page, cpu_addr[7:0]}, where base page is the committed 12-bit first-page number.
- R3: In the adder build (USE_ADDER=1), an access to CPU page $21 produces physical page base+1 modulo 4096, so base $FFF gives physical page $000.
- R4: In the two-register build (USE_ADDER=0), an access to CPU page $21 produces physical page equal to the committed second-page register, whatever its relation to the base.
- R5: A CPU address outside the window produces physical address {4'h0, cpu_addr}.
- R6: A low-byte write (wr_sel 0 for base, 2 for second page) only stages wr_data and leaves the mapping unchanged.
- R7: A high-nibble write (wr_sel 1 for base, 3 for second page) commits {wr_data[3:0], staged low byte} in the next cycle; wr_data[7:4] are ignored.
- R8: Reset (rst_n low, asynchronous) clears both committed page registers and both staged low bytes to zero.
- R9: In the adder build, writes with wr_sel 2 or 3 have no effect on the mapping.
- R10: With wr_en low, no register changes whatever wr_sel and wr_data hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the page registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 base low, 1 base high, 2 second low, 3 second high |
| wr_data | input | 8 | Write data (only bits 3:0 used for high writes) |
| cpu_addr | input | 16 | Processor address |
| phys_addr | output | 20 | Translated physical address |

## Verification
The hardest case to bring about is the wrap of the incremented page from $FFF to $000. It shows only when both halves of the base are loaded with all ones and the second window page is then read. The bench commits $FFF through the two-part write and then probes $2000 and $2100, expecting physical pages $FFF and $000. A second hard case is the gap between a staged low byte and its commit. The bench probes the window between the two writes to show that the old page number is still in use.

// File: rtl/pagewin_pkg.sv
package pagewin_pkg;
  typedef enum logic [1:0] {
    SEL_BASE_LO = 2'd0,
    SEL_BASE_HI = 2'd1,
    SEL_SEC_LO  = 2'd2,
    SEL_SEC_HI  = 2'd3
  } wsel_e;
endpackage

// File: rtl/pagewin_regs.sv
module pagewin_regs #(
  parameter int PAGE_W    = 12,
  parameter int DATA_W    = 8,
  parameter bit USE_ADDER = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [PAGE_W-1:0] base_q,
  output logic [PAGE_W-1:0] sec_q,
  output logic              base_commit,
  output logic              sec_commit
);
  import pagewin_pkg::*;
  localparam int HI_W = PAGE_W - DATA_W;

  logic [DATA_W-1:0] base_lo;

  // Event wires for the checker.
  assign base_commit = wr_en && (wr_sel == SEL_BASE_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_lo <= '0;
      base_q  <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_BASE_LO) base_lo <= wr_data;
      if (base_commit)           base_q  <= {wr_data[HI_W-1:0], base_lo};
    end
  end

  generate
    if (USE_ADDER) begin : g_no_sec
      assign sec_q      = '0;
      assign sec_commit = 1'b0;
    end else begin : g_sec
      logic [DATA_W-1:0] sec_lo;
      logic [PAGE_W-1:0] sec_r;
      assign sec_commit = wr_en && (wr_sel == SEL_SEC_HI);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sec_lo <= '0;
          sec_r  <= '0;
        end else if (wr_en) begin
          if (wr_sel == SEL_SEC_LO) sec_lo <= wr_data;
          if (sec_commit)           sec_r  <= {wr_data[HI_W-1:0], sec_lo};
        end
      end
      assign sec_q = sec_r;
    end
  endgenerate
endmodule

// File: rtl/pagewin_decode.sv
module pagewin_decode #(
  parameter int AW       = 16,
  parameter int OFF_W    = 8,
  parameter int WIN_PAGE = 'h20
) (
  input  logic [AW-1:0] cpu_addr,
  output logic          win_hit,
  output logic          win_upper
);
  localparam int PG_W = AW - OFF_W;
  localparam logic [PG_W-1:0] WIN_PG = PG_W'(WIN_PAGE);

  logic [PG_W-1:0] cpu_page;
  assign cpu_page  = cpu_addr[AW-1:OFF_W];
  // The window is an aligned pair: compare all page bits except the lowest.
  assign win_hit   = (cpu_page[PG_W-1:1] == WIN_PG[PG_W-1:1]);
  assign win_upper = cpu_page[0];
endmodule

// File: rtl/pagewin_xlate.sv
module pagewin_xlate #(
  parameter int AW        = 16,
  parameter int OFF_W     = 8,
  parameter int PAGE_W    = 12,
  parameter bit USE_ADDER = 1'b1
) (
  input  logic [AW-1:0]           cpu_addr,
  input  logic                    win_hit,
  input  logic                    win_upper,
  input  logic [PAGE_W-1:0]       base_q,
  input  logic [PAGE_W-1:0]       sec_q,
  output logic [PAGE_W+OFF_W-1:0] phys_addr
);
  localparam int PA_W = PAGE_W + OFF_W;

  function automatic logic [PAGE_W-1:0] succ_page(input logic [PAGE_W-1:0] p);
    return p + 1'b1;
  endfunction

  function automatic logic [PA_W-1:0] join_addr(input logic [PAGE_W-1:0] pg,
                                                 input logic [OFF_W-1:0]  off);
    return {pg, off};
  endfunction

  logic [PAGE_W-1:0] upper_page;
  logic [PAGE_W-1:0] win_page;

  assign upper_page = USE_ADDER ? succ_page(base_q) : sec_q;
  assign win_page   = win_upper ? upper_page : base_q;

  always_comb begin
    if (win_hit) phys_addr = join_addr(win_page, cpu_addr[OFF_W-1:0]);
    else         phys_addr = PA_W'(cpu_addr);
  end
endmodule

// File: rtl/pagewin_mapper.sv
module pagewin_mapper #(
  parameter int AW        = 16,
  parameter int OFF_W     = 8,
  parameter int PAGE_W    = 12,
  parameter int DATA_W    = 8,
  parameter int WIN_PAGE  = 'h20,
  parameter bit USE_ADDER = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [1:0]              wr_sel,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [AW-1:0]           cpu_addr,
  output logic [PAGE_W+OFF_W-1:0] phys_addr
);
  logic [PAGE_W-1:0] base_q;
  logic [PAGE_W-1:0] sec_q;
  logic              base_commit;
  logic              sec_commit;
  logic              win_hit;
  logic              win_upper;

  pagewin_regs #(.PAGE_W(PAGE_W), .DATA_W(DATA_W), .USE_ADDER(USE_ADDER)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .base_q(base_q), .sec_q(sec_q), .base_commit(base_commit), .sec_commit(sec_commit)
  );

  pagewin_decode #(.AW(AW), .OFF_W(OFF_W), .WIN_PAGE(WIN_PAGE)) u_dec (
    .cpu_addr(cpu_addr), .win_hit(win_hit), .win_upper(win_upper)
  );

  pagewin_xlate #(.AW(AW), .OFF_W(OFF_W), .PAGE_W(PAGE_W), .USE_ADDER(USE_ADDER)) u_xl (
    .cpu_addr(cpu_addr), .win_hit(win_hit), .win_upper(win_upper),
    .base_q(base_q), .sec_q(sec_q), .phys_addr(phys_addr)
  );
endmodule

// File: rtl/pagewin_mapper_chk.sv
module pagewin_mapper_chk #(
  parameter int AW        = 16,
  parameter int OFF_W     = 8,
  parameter int PAGE_W    = 12,
  parameter int DATA_W    = 8,
  parameter bit USE_ADDER = 1'b1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic [1:0]              wr_sel,
  input logic [DATA_W-1:0]       wr_data,
  input logic [AW-1:0]           cpu_addr,
  input logic [PAGE_W+OFF_W-1:0] phys_addr,
  input logic [PAGE_W-1:0]       base_q,
  input logic [PAGE_W-1:0]       sec_q,
  input logic                    base_commit,
  input logic                    win_hit,
  input logic                    win_upper
);
  localparam int HI_W = PAGE_W - DATA_W;
  localparam int PA_W = PAGE_W + OFF_W;

  // R8: while reset is held, both committed registers are zero.
  always @(posedge clk) begin
    if (!rst_n) a_r8_reset_zero: assert (base_q == '0 && sec_q == '0);
  end

  a_r5_outside_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    !win_hit |-> phys_addr == PA_W'(cpu_addr));

  a_r2_lower_page: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit && !win_upper) |-> phys_addr == {base_q, cpu_addr[OFF_W-1:0]});

  a_r3_adder_next: assert property (@(posedge clk) disable iff (!rst_n)
    (USE_ADDER && win_hit && win_upper) |->
      phys_addr[PA_W-1:OFF_W] == PAGE_W'(base_q + 1'b1));

  a_r4_second_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (!USE_ADDER && win_hit && win_upper) |-> phys_addr[PA_W-1:OFF_W] == sec_q);

  a_r6_low_stages_only: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0) |=> $stable(base_q));

  a_r7_high_commits: assert property (@(posedge clk) disable iff (!rst_n)
    base_commit |=> base_q[PAGE_W-1:DATA_W] == $past(wr_data[HI_W-1:0]));

  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(base_q) && $stable(sec_q)));

  a_r9_adder_no_sec: assert property (@(posedge clk) disable iff (!rst_n)
    (USE_ADDER && wr_en && wr_sel[1]) |=> $stable(base_q));
endmodule

bind pagewin_mapper pagewin_mapper_chk #(
  .AW(AW), .OFF_W(OFF_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W), .USE_ADDER(USE_ADDER)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .cpu_addr(cpu_addr), .phys_addr(phys_addr), .base_q(base_q), .sec_q(sec_q),
  .base_commit(base_commit), .win_hit(win_hit), .win_upper(win_upper)
);

// File: tb/pagewin_mapper_test.sv
module pagewin_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [7:0]  wr_data = 8'd0;
  logic [15:0] cpu_addr = 16'd0;
  logic [19:0] pa_add, pa_dual;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pagewin_mapper #(.USE_ADDER(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cpu_addr(cpu_addr), .phys_addr(pa_add));

  pagewin_mapper #(.USE_ADDER(1'b0)) uut_dual (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cpu_addr(cpu_addr), .phys_addr(pa_dual));

  // Table after base=$113, second=$114: {cpu address, expected physical} for both builds.
  localparam logic [35:0] VEC [8] = '{
    {16'h2000, 20'h11300}, {16'h20FF, 20'h113FF}, {16'h2100, 20'h11400},
    {16'h21FF, 20'h114FF}, {16'h1FFF, 20'h01FFF}, {16'h2200, 20'h02200},
    {16'h0000, 20'h00000}, {16'hFFFF, 20'h0FFFF}};

  task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, cpu_addr, act, exp);
    end
  endtask

  task automatic probe(input logic [15:0] a, input string req,
                       input logic [19:0] e_add, input logic [19:0] e_dual);
    @(negedge clk);
    cpu_addr = a;
    #1;
    chk(req, pa_add, e_add);
    chk(req, pa_dual, e_dual);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d, input logic en = 1'b1);
    @(negedge clk);
    wr_en = en; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    // R8: reset state; R3 page $21 is base+1, R4 second register zero.
    probe(16'h2034, "R8", 20'h00034, 20'h00034);
    probe(16'h2134, "R8", 20'h00134, 20'h00034);
    @(negedge clk); rst_n = 1'b1;

    wr(2'd0, 8'h13); wr(2'd1, 8'h01); wr(2'd2, 8'h14); wr(2'd3, 8'h01);
    foreach (VEC[i]) begin
      // R1/R2/R3/R4/R5 table walk
      probe(VEC[i][35:20], "R1 R2 R3 R4 R5 table", VEC[i][19:0], VEC[i][19:0]);
    end

    // R6: staged low byte leaves mapping alone.
    wr(2'd0, 8'h45);
    probe(16'h2010, "R6", 20'h11310, 20'h11310);
    // R7: commit with upper data bits ignored.
    wr(2'd1, 8'hF7);
    probe(16'h2010, "R7", 20'h74510, 20'h74510);
    probe(16'h2110, "R7 R3", 20'h74610, 20'h11410);

    // R4: second register used as is, even if not base+1. R9: adder ignores it.
    wr(2'd2, 8'h00); wr(2'd3, 8'hA2);
    probe(16'h2177, "R4 R9", 20'h74677, 20'h20077);

    // R10: strobe low, nothing changes.
    wr(2'd1, 8'h0C, 1'b0);
    wr(2'd3, 8'h0C, 1'b0);
    probe(16'h2001, "R10", 20'h74501, 20'h74501);
    probe(16'h2101, "R10", 20'h74601, 20'h20001);

    // R3: wrap from $FFF to $000.
    wr(2'd0, 8'hFF); wr(2'd1, 8'h0F);
    probe(16'h20AB, "R3 wrap", 20'hFFFAB, 20'hFFFAB);
    probe(16'h21AB, "R3 wrap", 20'h000AB, 20'h200AB);

    // R8: reset mid-run clears committed and staged values.
    wr(2'd0, 8'h55);
    @(negedge clk); rst_n = 1'b0;
    probe(16'h2100, "R8", 20'h00100, 20'h00000);
    @(negedge clk); rst_n = 1'b1;
    wr(2'd1, 8'h03);
    probe(16'h2000, "R8 staged", 20'h30000, 20'h30000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule